// File: doc/BRIEF.md
# Byte-wide flash program and erase sequencer

This block sits on the host side of a parallel, byte-wide flash device and turns single requests into the bus traffic the device expects. A request carries an operation kind, a target address, a data byte and a choice of completion-detection rule. It is taken over a valid/ready handshake. The sequencer then drives chip-enable, output-enable and write-enable with cycle counts set by parameters. It issues the unlock and command writes for the operation, and then reads the device's status byte over and over until it can decide whether the operation passed or failed. On failure it writes the return-to-read command once. It then reports the outcome with a one-cycle done strobe and a pass flag.

Four kinds of request exist: program a byte, erase the whole device, enter the shortened programming mode, and leave it. While the shortened mode is active, each program needs only two writes. Requests that make no sense in the present mode are refused without touching the bus. The bidirectional data bus is split into an output byte and an input byte. Pad control is left to the surrounding logic.

Top module: `flash_prog_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. While `req_ready` is high, all three strobes stay high. `req_ready` is low in the cycle after a request is taken.
- R2: Whenever `flash_we_n` is low, `flash_oe_n` is high and `flash_ce_n` is low.
- R3: Each write-enable pulse is low for exactly `T_WE_LO` cycles. Between two pulses, write enable is high for at least `T_WE_HI` cycles.
- R4: Outside the shortened mode, a program request (kind 0) produces, in this order, AAh at 555h, 55h at 2AAh, A0h at 555h, and then the data at the target address.
- R5: An erase request (kind 1) produces six writes in order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. During polling, a bit 7 of 1 is treated as the finished value.
- R6: With `req_toggle` low, polling reads the target address. The operation passes when status bit 7 equals the expected bit 7. On a mismatch with bit 5 set, exactly one more read is made, and it decides pass (bit 7 matches) or fail. On a mismatch with bit 5 clear, polling goes on.
- R7: With `req_toggle` high, bit 6 of two successive reads is compared. If it is unchanged, the result is pass. If it changed and bit 5 is clear, polling goes on. If it changed with bit 5 set, two fresh reads are made: an unchanged bit 6 means pass, a changed one means fail.
- R8: A failed verdict is followed by exactly one write of F0h at address 000h, and then done with pass low.
- R9: Kind 2 writes AAh@555h, 55h@2AAh, 20h@555h and enters the shortened mode. In that mode a program is A0h@555h followed by the data at the target address, and a failure does not leave the mode. Kind 3 writes 90h@000h, then 00h@000h, and leaves the mode.
- R10: Erase or kind 2 while in the shortened mode, and kind 3 outside it, complete with pass low and no bus cycle.
- R11: `done` is high for a single cycle per request, and `pass` is low whenever `done` is low.
- R12: Read data is captured only at the end of a window of `T_ACC` cycles with output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 2 | 0 program, 1 erase, 2 enter shortened mode, 3 leave it |
| req_addr | input | AW | Target address for program and polling |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1 selects the bit-6 toggle rule, 0 the bit-7 polling rule |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Outcome, valid with done |
| flash_addr | output | AW | Device address bus |
| flash_dout | output | 8 | Data driven toward the device |
| flash_din | input | 8 | Data returned by the device |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the sequencer with a setup of 2 cycles, a write pulse of 4, a recovery of 3 and an access latency of 3. Because the setup is longer than one cycle, the setup phase can be told apart from the pulse. The short latency lets a behavioural device model return the inverted byte until the final access cycle, so a capture taken one cycle early shows up as a wrong or never-ending verdict. The model can finish after a chosen number of busy reads, fail with bit 5 set, or finish on the very read after bit 5 rises. This exercises both polling rules along every branch, in normal and shortened mode.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    KIND_PROG    = 2'd0,
    KIND_ERASE   = 2'd1,
    KIND_BYP_ON  = 2'd2,
    KIND_BYP_OFF = 2'd3
  } kind_e;

  typedef enum logic [1:0] {VD_WAIT, VD_PASS, VD_FAIL, VD_CONFIRM} verdict_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_WR, SQ_RD, SQ_RST, SQ_DONE} sq_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_GAP} phase_e;

  typedef logic [2:0] step_t;

  localparam logic [10:0] ADR_KEY_A = 11'h555;
  localparam logic [10:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] CD_KEY1      = 8'hAA;
  localparam logic [7:0] CD_KEY2      = 8'h55;
  localparam logic [7:0] CD_PROG      = 8'hA0;
  localparam logic [7:0] CD_ERASE_PRE = 8'h80;
  localparam logic [7:0] CD_ERASE_ALL = 8'h10;
  localparam logic [7:0] CD_BYP_ON    = 8'h20;
  localparam logic [7:0] CD_BYP_X1    = 8'h90;
  localparam logic [7:0] CD_BYP_X2    = 8'h00;
  localparam logic [7:0] CD_READ      = 8'hF0;
endpackage

// File: rtl/fps_cmd_seq.sv
module fps_cmd_seq
  import fps_pkg::*;
#(
  parameter int AW = 16
) (
  input  kind_e          kind,
  input  logic           bypass,
  input  step_t          step,
  input  logic [AW-1:0]  tgt_addr,
  input  logic [7:0]     tgt_data,
  output logic [AW-1:0]  wr_addr,
  output logic [7:0]     wr_data,
  output logic           last
);
  localparam logic [AW-1:0] A_KEY_A = AW'(ADR_KEY_A);
  localparam logic [AW-1:0] A_KEY_B = AW'(ADR_KEY_B);

  always_comb begin
    wr_addr = A_KEY_A;
    wr_data = CD_KEY1;
    last    = 1'b0;
    unique case (kind)
      KIND_PROG: begin
        if (bypass) begin
          if (step == 3'd0) begin
            wr_data = CD_PROG;
          end else begin
            wr_addr = tgt_addr;
            wr_data = tgt_data;
            last    = 1'b1;
          end
        end else begin
          case (step)
            3'd0: ;
            3'd1: begin wr_addr = A_KEY_B; wr_data = CD_KEY2; end
            3'd2: wr_data = CD_PROG;
            default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
          endcase
        end
      end
      KIND_ERASE: begin
        case (step)
          3'd0, 3'd3: ;
          3'd1, 3'd4: begin wr_addr = A_KEY_B; wr_data = CD_KEY2; end
          3'd2: wr_data = CD_ERASE_PRE;
          default: begin wr_data = CD_ERASE_ALL; last = 1'b1; end
        endcase
      end
      KIND_BYP_ON: begin
        case (step)
          3'd0: ;
          3'd1: begin wr_addr = A_KEY_B; wr_data = CD_KEY2; end
          default: begin wr_data = CD_BYP_ON; last = 1'b1; end
        endcase
      end
      default: begin
        wr_addr = '0;
        if (step == 3'd0) begin
          wr_data = CD_BYP_X1;
        end else begin
          wr_data = CD_BYP_X2;
          last    = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/fps_bus_cycle.sv
module fps_bus_cycle
  import fps_pkg::*;
#(
  parameter int AW      = 16,
  parameter int T_SETUP = 1,
  parameter int T_WE_LO = 4,
  parameter int T_WE_HI = 3,
  parameter int T_ACC   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_wr,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     data_i,
  input  logic [7:0]     din,
  output logic           idle,
  output logic           done,
  output logic [2:0]     stat,
  output logic [AW-1:0]  addr_o,
  output logic [7:0]     dout,
  output logic           ce_n,
  output logic           oe_n,
  output logic           we_n
);
  localparam int TM1  = (T_SETUP > T_WE_LO) ? T_SETUP : T_WE_LO;
  localparam int TM2  = (T_WE_HI > T_ACC) ? T_WE_HI : T_ACC;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam logic [CW-1:0] C_SETUP = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] C_WE_LO = CW'(T_WE_LO - 1);
  localparam logic [CW-1:0] C_WE_HI = CW'(T_WE_HI - 1);
  localparam logic [CW-1:0] C_ACC   = CW'(T_ACC - 1);

  phase_e          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [7:0]      data_q;
  logic [2:0]      stat_q;
  logic            load_req, load_stat, cnt_zero;
  logic            unused_din_low;

  assign unused_din_low = ^din[4:0];
  assign cnt_zero  = (cnt_q == '0);
  assign load_req  = start && (ph_q == PH_IDLE);
  assign load_stat = (ph_q == PH_ACT) && cnt_zero && !wr_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin ph_d = PH_SETUP; cnt_d = C_SETUP; end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_ACT;
          cnt_d = wr_q ? C_WE_LO : C_ACC;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (cnt_zero) begin ph_d = PH_GAP; cnt_d = C_WE_HI; end
        else cnt_d = cnt_q - 1'b1;
      end
      default: begin
        if (cnt_zero) ph_d = PH_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      stat_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (load_req) begin
        wr_q   <= is_wr;
        addr_q <= addr_i;
        data_q <= data_i;
      end
      if (load_stat) stat_q <= din[7:5];
    end
  end

  assign idle   = (ph_q == PH_IDLE);
  assign done   = (ph_q == PH_GAP) && cnt_zero;
  assign stat   = stat_q;
  assign addr_o = addr_q;
  assign dout   = data_q;
  assign ce_n   = !((ph_q == PH_SETUP) || (ph_q == PH_ACT));
  assign we_n   = !((ph_q == PH_ACT) && wr_q);
  assign oe_n   = !((ph_q == PH_ACT) && !wr_q);
endmodule

// File: rtl/fps_poll_eval.sv
module fps_poll_eval
  import fps_pkg::*;
(
  input  logic      tog_mode,
  input  logic      confirming,
  input  logic      exp7,
  input  logic [2:0] cur,
  input  logic      prev6,
  output verdict_e  verdict
);
  logic settled;

  assign settled = tog_mode ? (cur[1] == prev6) : (cur[2] == exp7);

  always_comb begin
    if (settled)         verdict = VD_PASS;
    else if (confirming) verdict = VD_FAIL;
    else if (cur[0])     verdict = VD_CONFIRM;
    else                 verdict = VD_WAIT;
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW      = 16,
  parameter int T_SETUP = 1,
  parameter int T_WE_LO = 4,
  parameter int T_WE_HI = 3,
  parameter int T_ACC   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic [AW-1:0]  req_addr,
  input  logic [7:0]     req_data,
  input  logic           req_toggle,
  output logic           done,
  output logic           pass,
  output logic [AW-1:0]  flash_addr,
  output logic [7:0]     flash_dout,
  input  logic [7:0]     flash_din,
  output logic           flash_ce_n,
  output logic           flash_oe_n,
  output logic           flash_we_n
);
  sq_state_e      st_q, st_d;
  step_t          step_q, step_d;
  kind_e          kind_q, req_kind_e;
  logic [AW-1:0]  tgt_addr_q;
  logic [7:0]     tgt_data_q;
  logic           tog_q;
  logic           byp_q, byp_d;
  logic           prev6_q, prev6_d;
  logic           primed_q, primed_d;
  logic           confirm_q, confirm_d;
  logic           result_q, result_d;
  logic           accept, req_ok, exp7;

  logic [AW-1:0]  seq_addr, bus_addr;
  logic [7:0]     seq_data, bus_data;
  logic           seq_last;
  logic           bus_start, bus_wr, bus_idle, bus_done;
  logic [2:0]     bus_stat;
  verdict_e       verdict;

  assign req_kind_e = kind_e'(req_kind);
  assign accept     = req_valid && (st_q == SQ_IDLE);
  assign exp7       = (kind_q == KIND_ERASE) ? 1'b1 : tgt_data_q[7];

  always_comb begin
    unique case (req_kind_e)
      KIND_PROG:    req_ok = 1'b1;
      KIND_ERASE,
      KIND_BYP_ON:  req_ok = !byp_q;
      default:      req_ok = byp_q;
    endcase
  end

  fps_cmd_seq #(.AW(AW)) u_cmd (
    .kind     (kind_q),
    .bypass   (byp_q),
    .step     (step_q),
    .tgt_addr (tgt_addr_q),
    .tgt_data (tgt_data_q),
    .wr_addr  (seq_addr),
    .wr_data  (seq_data),
    .last     (seq_last)
  );

  assign bus_start = ((st_q == SQ_WR) || (st_q == SQ_RD) || (st_q == SQ_RST)) && bus_idle;
  assign bus_wr    = (st_q != SQ_RD);

  always_comb begin
    bus_addr = tgt_addr_q;
    bus_data = seq_data;
    if (st_q == SQ_WR) begin
      bus_addr = seq_addr;
    end else if (st_q == SQ_RST) begin
      bus_addr = '0;
      bus_data = CD_READ;
    end
  end

  fps_bus_cycle #(
    .AW(AW), .T_SETUP(T_SETUP), .T_WE_LO(T_WE_LO), .T_WE_HI(T_WE_HI), .T_ACC(T_ACC)
  ) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bus_start),
    .is_wr  (bus_wr),
    .addr_i (bus_addr),
    .data_i (bus_data),
    .din    (flash_din),
    .idle   (bus_idle),
    .done   (bus_done),
    .stat   (bus_stat),
    .addr_o (flash_addr),
    .dout   (flash_dout),
    .ce_n   (flash_ce_n),
    .oe_n   (flash_oe_n),
    .we_n   (flash_we_n)
  );

  fps_poll_eval u_eval (
    .tog_mode   (tog_q),
    .confirming (confirm_q),
    .exp7       (exp7),
    .cur        (bus_stat),
    .prev6      (prev6_q),
    .verdict    (verdict)
  );

  always_comb begin
    st_d      = st_q;
    step_d    = step_q;
    byp_d     = byp_q;
    prev6_d   = prev6_q;
    primed_d  = primed_q;
    confirm_d = confirm_q;
    result_d  = result_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          step_d   = '0;
          result_d = 1'b0;
          st_d     = req_ok ? SQ_WR : SQ_DONE;
        end
      end
      SQ_WR: begin
        if (bus_done) begin
          if (!seq_last) begin
            step_d = step_q + 1'b1;
          end else if ((kind_q == KIND_PROG) || (kind_q == KIND_ERASE)) begin
            st_d      = SQ_RD;
            primed_d  = 1'b0;
            confirm_d = 1'b0;
          end else begin
            byp_d    = (kind_q == KIND_BYP_ON);
            result_d = 1'b1;
            st_d     = SQ_DONE;
          end
        end
      end
      SQ_RD: begin
        if (bus_done) begin
          if (tog_q && !primed_q) begin
            prev6_d  = bus_stat[1];
            primed_d = 1'b1;
          end else begin
            unique case (verdict)
              VD_PASS: begin result_d = 1'b1; st_d = SQ_DONE; end
              VD_FAIL: st_d = SQ_RST;
              VD_CONFIRM: begin
                confirm_d = 1'b1;
                prev6_d   = bus_stat[1];
                if (tog_q) primed_d = 1'b0;
              end
              default: prev6_d = bus_stat[1];
            endcase
          end
        end
      end
      SQ_RST: begin
        if (bus_done) begin
          result_d = 1'b0;
          st_d     = SQ_DONE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      step_q     <= '0;
      byp_q      <= 1'b0;
      prev6_q    <= 1'b0;
      primed_q   <= 1'b0;
      confirm_q  <= 1'b0;
      result_q   <= 1'b0;
      kind_q     <= KIND_PROG;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      tog_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      step_q    <= step_d;
      byp_q     <= byp_d;
      prev6_q   <= prev6_d;
      primed_q  <= primed_d;
      confirm_q <= confirm_d;
      result_q  <= result_d;
      if (accept) begin
        kind_q     <= req_kind_e;
        tgt_addr_q <= req_addr;
        tgt_data_q <= req_data;
        tog_q      <= req_toggle;
      end
    end
  end

  assign req_ready = (st_q == SQ_IDLE);
  assign done      = (st_q == SQ_DONE);
  assign pass      = done && result_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int T_WE_LO = 4,
  parameter int T_WE_HI = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic pass,
  input logic flash_ce_n,
  input logic flash_oe_n,
  input logic flash_we_n
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      lo_cnt <= flash_we_n ? '0 : lo_cnt + 1'b1;
      if (!flash_we_n)          hi_cnt <= '0;
      else if (hi_cnt != '1)    hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r1_bus_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_ce_n && flash_we_n && flash_oe_n));

  a_r2_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> (flash_oe_n && !flash_ce_n));

  a_r3_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (lo_cnt == 16'(T_WE_LO)));

  a_r3_we_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> (hi_cnt >= 16'(T_WE_HI)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.T_WE_LO(T_WE_LO), .T_WE_HI(T_WE_HI)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .pass       (pass),
  .flash_ce_n (flash_ce_n),
  .flash_oe_n (flash_oe_n),
  .flash_we_n (flash_we_n)
);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int AW = 16, TS = 2, TLO = 4, THI = 3, TACC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_toggle, done, pass;
  logic [1:0] req_kind;
  logic [AW-1:0] req_addr, flash_addr;
  logic [7:0] req_data, flash_dout, flash_din;
  logic flash_ce_n, flash_oe_n, flash_we_n;

  flash_prog_seq #(.AW(AW), .T_SETUP(TS), .T_WE_LO(TLO), .T_WE_HI(THI), .T_ACC(TACC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .done(done), .pass(pass), .flash_addr(flash_addr), .flash_dout(flash_dout),
    .flash_din(flash_din), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Behavioural device model: busy reads, then an outcome (0 finish, 1 fail, 2 finish after bit 5)
  int busy_left = 0, outcome = 0, acc_cnt = 0;
  bit tog = 1'b0, race_used = 1'b0;
  logic [7:0] exp_final = 8'hFF, rd_val = 8'h00;

  function automatic logic [7:0] status(input bit b5);
    return {~exp_final[7], tog, b5, 5'b01010};
  endfunction

  always @(negedge flash_oe_n) begin
    if (rst_n === 1'b1) begin
      if (busy_left > 0) begin
        rd_val = status(1'b0); tog = ~tog; busy_left--;
      end else if (outcome == 1) begin
        rd_val = status(1'b1); tog = ~tog;
      end else if (outcome == 2 && !race_used) begin
        rd_val = status(1'b1); tog = ~tog; race_used = 1'b1;
      end else begin
        rd_val = exp_final;
      end
    end
  end

  always @(posedge clk) acc_cnt <= flash_oe_n ? 0 : acc_cnt + 1;
  // R12: value only valid from the last access cycle on
  assign flash_din = (acc_cnt >= TACC - 1) ? rd_val : ~rd_val;

  logic [AW-1:0] got_a[$], exp_a[$];
  logic [7:0]    got_d[$], exp_d[$];

  always @(posedge flash_we_n) begin
    if (rst_n === 1'b1) begin
      got_a.push_back(flash_addr);
      got_d.push_back(flash_dout);
    end
  end

  // Per-clock comparison of strobe behaviour
  int lo_run = 0, hi_run = 1000;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (req_ready) chk(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes idle while ready",
                         {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
      if (!flash_we_n) chk(flash_oe_n && !flash_ce_n, "R2 oe high ce low in write",
                           {flash_oe_n, flash_ce_n}, 2'b10);
      if (!done) chk(!pass, "R11 pass only with done", pass, 0);
      if (!flash_we_n) begin
        if (lo_run == 0) chk(hi_run >= THI, "R3 we high gap", hi_run, THI);
        lo_run++; hi_run = 0;
      end else begin
        if (lo_run > 0) chk(lo_run == TLO, "R3 we low width", lo_run, TLO);
        lo_run = 0; hi_run++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ew(input logic [AW-1:0] a, input logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  task automatic do_req(input logic [1:0] kind, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit tg, input int busy, input int oc, input bit exp_pass,
                        input string tag);
    int n;
    got_a.delete(); got_d.delete();
    busy_left = busy; outcome = oc; tog = 1'b0; race_used = 1'b0;
    exp_final = (kind == 2'd1) ? 8'hFF : d;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_data = d; req_toggle = tg;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R1 ready low after accept"}, req_ready, 0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, {tag, " done reached"}, done, 1);
    chk(pass == exp_pass, {tag, " verdict"}, pass, exp_pass);
    @(negedge clk);
    chk(!done, {tag, " R11 single-cycle done"}, done, 0);
    chk(got_a.size() == exp_a.size(), {tag, " write count"}, got_a.size(), exp_a.size());
    for (int i = 0; i < got_a.size() && i < exp_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], {tag, " write address"}, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], {tag, " write data"}, got_d[i], exp_d[i]);
    end
    exp_a.delete(); exp_d.delete();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; req_data = '0; req_toggle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && flash_ce_n && flash_we_n && flash_oe_n, "R1 reset state",
        {req_ready, done, flash_ce_n, flash_we_n, flash_oe_n}, 5'b10111);

    // R4 R6 R12: normal program, bit-7 polling, finishes after busy reads
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'h1234, 8'hC3);
    do_req(2'd0, 16'h1234, 8'hC3, 1'b0, 3, 0, 1'b1, "R4 R6 R12 program poll pass");
    // R6 R8: bit 5 set and still wrong -> reset write
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'hBEEF, 8'h5A);
    ew(16'h0000, 8'hF0);
    do_req(2'd0, 16'hBEEF, 8'h5A, 1'b0, 2, 1, 1'b0, "R6 R8 program poll fail");
    // R6: finishes on the read after bit 5
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'h0042, 8'h81);
    do_req(2'd0, 16'h0042, 8'h81, 1'b0, 1, 2, 1'b1, "R6 confirm read pass");
    // R5: erase with bit-7 polling
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'h80);
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'h10);
    do_req(2'd1, 16'h7777, 8'h00, 1'b0, 2, 0, 1'b1, "R5 erase poll pass");
    // R5 R7: erase with toggle rule
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'h80);
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'h10);
    do_req(2'd1, 16'h0100, 8'h00, 1'b1, 3, 0, 1'b1, "R5 R7 erase toggle pass");
    // R7 R8: toggle rule failure
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'h0200, 8'h3C);
    ew(16'h0000, 8'hF0);
    do_req(2'd0, 16'h0200, 8'h3C, 1'b1, 1, 1, 1'b0, "R7 R8 toggle fail");
    // R7: toggle rule, finish right after bit 5
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'h0300, 8'h7E);
    do_req(2'd0, 16'h0300, 8'h7E, 1'b1, 1, 2, 1'b1, "R7 toggle confirm pass");
    // R10: leave shortened mode while not in it
    do_req(2'd3, 16'h0000, 8'h00, 1'b0, 0, 0, 1'b0, "R10 exit refused");
    // R9: enter shortened mode
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'h20);
    do_req(2'd2, 16'h0000, 8'h00, 1'b0, 0, 0, 1'b1, "R9 enter mode");
    // R10: erase and re-enter refused in shortened mode
    do_req(2'd1, 16'h0000, 8'h00, 1'b0, 0, 0, 1'b0, "R10 erase refused");
    do_req(2'd2, 16'h0000, 8'h00, 1'b0, 0, 0, 1'b0, "R10 enter refused");
    // R9: two-write program
    ew(16'h0555, 8'hA0); ew(16'h4321, 8'h99);
    do_req(2'd0, 16'h4321, 8'h99, 1'b0, 2, 0, 1'b1, "R9 short program pass");
    // R9 R8: failure keeps the mode
    ew(16'h0555, 8'hA0); ew(16'h0010, 8'h11); ew(16'h0000, 8'hF0);
    do_req(2'd0, 16'h0010, 8'h11, 1'b0, 1, 1, 1'b0, "R9 R8 short program fail");
    ew(16'h0555, 8'hA0); ew(16'h0011, 8'hE7);
    do_req(2'd0, 16'h0011, 8'hE7, 1'b1, 2, 0, 1'b1, "R9 mode kept after fail");
    // R9: leave mode
    ew(16'h0000, 8'h90); ew(16'h0000, 8'h00);
    do_req(2'd3, 16'h0000, 8'h00, 1'b0, 0, 0, 1'b1, "R9 exit mode");
    // R4: full sequence again after leaving
    ew(16'h0555, 8'hAA); ew(16'h02AA, 8'h55); ew(16'h0555, 8'hA0); ew(16'hFFFF, 8'h00);
    do_req(2'd0, 16'hFFFF, 8'h00, 1'b0, 0, 0, 1'b1, "R4 program after exit");

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule